// File: doc/BRIEF.md
# Prescaled Up-Counting Update Timer

This block is a 16-bit up-counter fed by a programmable clock divider and bounded by a reload limit. Each time the count reaches the limit and steps on, it restarts at zero and raises an update event. The event loads new divider and limit settings, sets a sticky status flag, drives a level interrupt line and emits a single-cycle DMA request pulse. Software can also force an update at any time, which restarts both the divider and the counter.

Software reaches the block through a plain word bus. Writes are captured on the clock edge where `bus_we_i` is high. Reads are combinational from `bus_addr_i`, which carries a byte offset. A control bit chooses whether forced updates also raise the flag and the DMA pulse, or whether only a real overflow does.

Top module: `upd_timer`

## Requirements
- R1: After reset, every register reads 0 except the reload register at 0x2C, which reads 0xFFFF. `irq_o` and `dma_req_o` are low and the count is 0.
- R2: While the run bit (bit 0 of the control register at 0x00) is 1, the count rises by one every (P+1) clocks, where P is the active divider value. While the run bit is 0, the count and the divider hold their values.
- R3: On the counter tick where the count equals the active reload value L, the count goes to 0 and an update event occurs, which sets the flag (bit 0 of status at 0x10). Updates therefore recur every (P+1)*(L+1) clocks.
- R4: Writes to the divider (0x28, 16 bits) and reload (0x2C, 16 bits) registers land in preload copies and read back at once. The active values change only at the next update event.
- R5: Writing 1 to bit 0 of the event register at 0x14 forces an update: the divider and the count are cleared and both preloads become active. This register always reads 0.
- R6: When bit 2 of the control register is 1, a forced update sets neither the flag nor the DMA pulse, while an overflow still does. When that bit is 0, a forced update sets the flag.
- R7: Writing 0 to status bit 0 clears the flag, and writing 1 leaves it unchanged. If an update and a clearing write fall in the same cycle, the flag stays set.
- R8: `irq_o` is high exactly while the flag is set and interrupt enable (bit 0 at 0x0C) is 1.
- R9: When DMA enable (bit 8 at 0x0C) is 1, each flag-setting update gives a `dma_req_o` pulse one clock wide, in the clock after the update edge.
- R10: A read of 0x24 returns the count in bits 15:0, the flag in bit 31, and 0 in bits 30:16.
- R11: With a divider of 1999 and a reload of 36000 on a 72 MHz clock, the update rate is within 1% of 1 Hz (the count advances every 2000 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the divider input |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, 0 for unmapped offsets |
| irq_o | output | 1 | Level interrupt: flag AND interrupt enable |
| dma_req_o | output | 1 | One-clock DMA request per flagged update |

## Verification
The embedded properties check on every cycle that the count steps by one on a tick, holds without a tick, and returns to zero after a wrap or a forced update. They also check that the divider never exceeds its active limit, that active values change only at update events, that the flag stays set until it is cleared and is set by every overflow, and that a forced update under the overflow-only setting never sets it. Only the directed scenarios can show the measured update period, the delayed effect of preloaded settings on a running count, the exact edge of the DMA pulse, the read-back layout including the mirrored flag, and the roughly 1 Hz result of the reference configuration.

// File: rtl/upd_timer_pkg.sv
package upd_timer_pkg;

  localparam int unsigned ADDR_W = 8;

  // byte offsets; software relies on these
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_EVGEN = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_PSC   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_ARR   = 8'h2C;

  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned SRC_BIT   = 2;
  localparam int unsigned IRQE_BIT  = 0;
  localparam int unsigned DMAE_BIT  = 8;
  localparam int unsigned FLAG_BIT  = 0;
  localparam int unsigned FORCE_BIT = 0;

  typedef struct packed {
    logic ovf_only;
    logic run;
  } ctrl_t;

  typedef struct packed {
    logic dma_en;
    logic irq_en;
  } ien_t;

endpackage

// File: rtl/upd_timer_prescaler.sv
module upd_timer_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             force_i,
  input  logic             ovf_i,
  input  logic [PSC_W-1:0] psc_pre_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] psc_act_q;

  assign tick_o = run_i && (div_q == psc_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (force_i) begin
      div_q <= '0;
    end else if (run_i) begin
      div_q <= tick_o ? '0 : div_q + 1'b1;
    end
  end

  // active divider loads only on an update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_act_q <= '0;
    end else if (force_i || ovf_i) begin
      psc_act_q <= psc_pre_i;
    end
  end

  p_div_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= psc_act_q);

  p_div_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !force_i |=> $stable(div_q));

  p_psc_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(psc_act_q) |-> $past(force_i || ovf_i));

endmodule

// File: rtl/upd_timer_counter.sv
module upd_timer_counter #(
  parameter int unsigned             CNT_W   = 16,
  parameter logic [CNT_W-1:0]        ARR_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] arr_pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] arr_act_q;

  assign ovf_o = tick_i && (cnt_q == arr_act_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (force_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= ovf_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_act_q <= ARR_RST;
    end else if (force_i || ovf_o) begin
      arr_act_q <= arr_pre_i;
    end
  end

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == '0);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !ovf_o && !force_i |=> cnt_q == $past(cnt_q) + 1'b1);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !force_i |=> $stable(cnt_q));

  p_force_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> cnt_q == '0);

  p_arr_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(arr_act_q) |-> $past(force_i || ovf_o));

endmodule

// File: rtl/upd_timer_regs.sv
module upd_timer_regs
  import upd_timer_pkg::*;
#(
  parameter int unsigned      CNT_W   = 16,
  parameter int unsigned      PSC_W   = 16,
  parameter int unsigned      DATA_W  = 32,
  parameter logic [CNT_W-1:0] ARR_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ovf_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              run_o,
  output logic              force_o,
  output logic [PSC_W-1:0]  psc_pre_o,
  output logic [CNT_W-1:0]  arr_pre_o,
  output logic              irq_o,
  output logic              dma_req_o
);

  localparam int unsigned MIRROR_BIT = DATA_W - 1;

  ctrl_t            ctrl_q;
  ien_t             ien_q;
  logic             flag_q;
  logic             dma_q;
  logic [PSC_W-1:0] psc_pre_q;
  logic [CNT_W-1:0] arr_pre_q;

  logic wr_ctrl, wr_ien, wr_stat, wr_evgen, wr_psc, wr_arr;
  logic flag_set, flag_clr;
  logic unused_wdata;

  assign wr_ctrl  = bus_we_i && (bus_addr_i == OFS_CTRL);
  assign wr_ien   = bus_we_i && (bus_addr_i == OFS_IEN);
  assign wr_stat  = bus_we_i && (bus_addr_i == OFS_STAT);
  assign wr_evgen = bus_we_i && (bus_addr_i == OFS_EVGEN);
  assign wr_psc   = bus_we_i && (bus_addr_i == OFS_PSC);
  assign wr_arr   = bus_we_i && (bus_addr_i == OFS_ARR);

  assign unused_wdata = ^bus_wdata_i;

  assign force_o  = wr_evgen && bus_wdata_i[FORCE_BIT];
  assign flag_set = ovf_i || (force_o && !ctrl_q.ovf_only);
  assign flag_clr = wr_stat && !bus_wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run      <= bus_wdata_i[RUN_BIT];
        ctrl_q.ovf_only <= bus_wdata_i[SRC_BIT];
      end
      if (wr_ien) begin
        ien_q.irq_en <= bus_wdata_i[IRQE_BIT];
        ien_q.dma_en <= bus_wdata_i[DMAE_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_pre_q <= '0;
      arr_pre_q <= ARR_RST;
    end else begin
      if (wr_psc) psc_pre_q <= bus_wdata_i[PSC_W-1:0];
      if (wr_arr) arr_pre_q <= bus_wdata_i[CNT_W-1:0];
    end
  end

  // set beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      dma_q <= flag_set && ien_q.dma_en;
    end
  end

  assign run_o     = ctrl_q.run;
  assign psc_pre_o = psc_pre_q;
  assign arr_pre_o = arr_pre_q;
  assign irq_o     = flag_q && ien_q.irq_en;
  assign dma_req_o = dma_q;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_CTRL: begin
        bus_rdata_o[RUN_BIT] = ctrl_q.run;
        bus_rdata_o[SRC_BIT] = ctrl_q.ovf_only;
      end
      OFS_IEN: begin
        bus_rdata_o[IRQE_BIT] = ien_q.irq_en;
        bus_rdata_o[DMAE_BIT] = ien_q.dma_en;
      end
      OFS_STAT: bus_rdata_o[FLAG_BIT] = flag_q;
      OFS_CNT: begin
        bus_rdata_o[CNT_W-1:0] = cnt_i;
        bus_rdata_o[MIRROR_BIT] = flag_q;
      end
      OFS_PSC: bus_rdata_o[PSC_W-1:0] = psc_pre_q;
      OFS_ARR: bus_rdata_o[CNT_W-1:0] = arr_pre_q;
      default: bus_rdata_o = '0;
    endcase
  end

  p_flag_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !flag_clr |=> flag_q);

  p_ovf_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_q);

  p_src_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_o && ctrl_q.ovf_only && !ovf_i && !flag_q |=> !flag_q && !dma_q);

  p_dma_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_q |-> $past(ien_q.dma_en));

endmodule

// File: rtl/upd_timer.sv
module upd_timer
  import upd_timer_pkg::*;
#(
  parameter int unsigned      CNT_W   = 16,
  parameter int unsigned      PSC_W   = 16,
  parameter int unsigned      DATA_W  = 32,
  parameter logic [CNT_W-1:0] ARR_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              dma_req_o
);

  logic             run, force_upd, tick, ovf;
  logic [PSC_W-1:0] psc_pre;
  logic [CNT_W-1:0] arr_pre;
  logic [CNT_W-1:0] cnt;

  upd_timer_regs #(
    .CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W), .ARR_RST(ARR_RST)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .ovf_i      (ovf),
    .cnt_i      (cnt),
    .run_o      (run),
    .force_o    (force_upd),
    .psc_pre_o  (psc_pre),
    .arr_pre_o  (arr_pre),
    .irq_o      (irq_o),
    .dma_req_o  (dma_req_o)
  );

  upd_timer_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .force_i  (force_upd),
    .ovf_i    (ovf),
    .psc_pre_i(psc_pre),
    .tick_o   (tick)
  );

  upd_timer_counter #(.CNT_W(CNT_W), .ARR_RST(ARR_RST)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .force_i  (force_upd),
    .arr_pre_i(arr_pre),
    .cnt_o    (cnt),
    .ovf_o    (ovf)
  );

  p_irq_needs_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ovf || force_upd || bus_we_i));

endmodule

// File: tb/tb_upd_timer.sv
module tb_upd_timer;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STAT = 8'h10,
                         A_EVG = 8'h14, A_CNT = 8'h24, A_PSC = 8'h28,
                         A_ARR = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, dma;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  upd_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .dma_req_o(dma)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_IEN, v);  chk("R1 ien", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(A_PSC, v);  chk("R1 psc", v, 0);
    rd(A_ARR, v);  chk("R1 arr", v, 32'h0000_FFFF);
    rd(A_CNT, v);  chk("R1 cnt", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 dma", {31'b0, dma}, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(A_ARR, 4); wr(A_EVG, 1); wr(A_STAT, 0);
    wr(A_IEN, 32'h101);
    wr(A_CTRL, 1);
    tick(4);
    rd(A_CNT, v); chk("R3 cnt at limit", v, 4);
    chk("R8 irq before wrap", {31'b0, irq}, 0);
    tick(1);
    rd(A_CNT, v); chk("R3 wrap to zero+flag", v, 32'h8000_0000);
    chk("R8 irq after wrap", {31'b0, irq}, 1);
    chk("R9 dma pulse", {31'b0, dma}, 1);
    tick(1);
    chk("R9 dma one cycle", {31'b0, dma}, 0);
    chk("R8 irq held", {31'b0, irq}, 1);
    wr(A_CTRL, 0);
    wr(A_STAT, 1);
    rd(A_STAT, v); chk("R7 write 1 keeps flag", v, 1);
    wr(A_STAT, 0);
    rd(A_STAT, v); chk("R7 write 0 clears", v, 0);
    chk("R8 irq drops", {31'b0, irq}, 0);
    wr(A_IEN, 32'h100);
    wr(A_EVG, 1);
    rd(A_STAT, v); chk("R6 forced sets flag", v, 1);
    chk("R8 irq masked", {31'b0, irq}, 0);
    chk("R9 dma on forced", {31'b0, dma}, 1);
    wr(A_STAT, 0);
  endtask

  task automatic t_period();
    int first = -1, second = -1, pulses = 0, wide = 0;
    logic prev = 1'b0;
    wr(A_PSC, 1); wr(A_ARR, 2); wr(A_EVG, 1); wr(A_STAT, 0);
    wr(A_CTRL, 1);
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (dma) begin
        pulses++;
        if (first < 0) first = i; else if (second < 0) second = i;
        if (prev) wide++;
      end
      prev = dma;
    end
    chk("R3 period (P+1)*(L+1)", second - first, 6);
    chk("R3 pulse count", pulses, 5);
    chk("R9 no wide pulse", wide, 0);
    wr(A_CTRL, 0); wr(A_STAT, 0);
  endtask

  task automatic t_preload();
    logic [31:0] v, c;
    wr(A_PSC, 1); wr(A_ARR, 2); wr(A_EVG, 1); wr(A_STAT, 0);
    wr(A_PSC, 0); wr(A_ARR, 7);
    rd(A_PSC, v); chk("R4 psc readback", v, 0);
    rd(A_ARR, v); chk("R4 arr readback", v, 7);
    wr(A_CTRL, 1);
    tick(5);
    rd(A_CNT, v); chk("R4 old psc still used", v, 2);
    tick(1);
    rd(A_CNT, v); chk("R4 old limit wraps", v, 32'h8000_0000);
    tick(1);
    rd(A_CNT, v); chk("R4 new psc active", v, 32'h8000_0001);
    tick(1);
    rd(A_CNT, v); chk("R4 new psc step", v, 32'h8000_0002);
    wr(A_CTRL, 0);
    rd(A_CNT, c);
    tick(10);
    rd(A_CNT, v); chk("R2 stopped holds", v, c);
    wr(A_STAT, 0);
  endtask

  task automatic t_force();
    logic [31:0] v;
    wr(A_CTRL, 4); wr(A_STAT, 0);
    rd(A_CNT, v); checks++;
    if (v[15:0] == 0) begin
      errors++; $display("FAIL R5 precondition: actual 0x%08h expected nonzero", v);
    end
    wr(A_EVG, 1);
    chk("R6 no dma when ovf-only", {31'b0, dma}, 0);
    rd(A_CNT, v); chk("R5 force clears, R6 no flag", v, 0);
    rd(A_EVG, v); chk("R5 event reg reads 0", v, 0);
    wr(A_CTRL, 0);
    wr(A_EVG, 1);
    chk("R6 dma on forced", {31'b0, dma}, 1);
    rd(A_STAT, v); chk("R6 forced flag src=0", v, 1);
    wr(A_STAT, 0);
    wr(A_CTRL, 5);
    tick(7);
    rd(A_CNT, v); chk("R6 cnt before ovf", v, 7);
    tick(1);
    rd(A_CNT, v); chk("R6 R10 ovf flag mirrored", v, 32'h8000_0000);
    wr(A_CTRL, 0); wr(A_STAT, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    wr(A_PSC, 0); wr(A_ARR, 0); wr(A_EVG, 1);
    wr(A_CTRL, 1);
    wr(A_STAT, 0);
    rd(A_STAT, v); chk("R7 set beats clear", v, 1);
    wr(A_CTRL, 0); wr(A_STAT, 0);
    rd(A_STAT, v); chk("R7 clear when idle", v, 0);
  endtask

  task automatic t_reference();
    logic [31:0] v;
    int n = 0;
    longint mhz;
    wr(A_PSC, 1999); wr(A_ARR, 36000); wr(A_EVG, 1); wr(A_STAT, 0);
    wr(A_CTRL, 1);
    tick(5999);
    rd(A_CNT, v); chk("R11 before third tick", v, 2);
    tick(1);
    rd(A_CNT, v); chk("R11 third tick", v, 3);
    do begin
      @(negedge clk); n++;
      rd(A_CNT, v);
    end while (v[15:0] != 4 && n < 5000);
    chk("R11 tick spacing", n, 2000);
    mhz = 64'd72_000_000_000 / (longint'(n) * 64'd36001);
    checks++;
    if (mhz < 990 || mhz > 1010) begin
      errors++; $display("FAIL R11 rate: actual %0d mHz expected 1000 mHz", mhz);
    end
    wr(A_CTRL, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_wrap();
    t_period();
    t_preload();
    t_force();
    t_set_wins();
    t_reference();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule